// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It runs on the system clock and uses an enable pulse at sixteen times the bit rate. It synchronises the line input and waits for a falling edge. It confirms the start bit at its centre, then takes a majority vote on three samples around the centre of each following bit, so that short noise spikes do not corrupt the character. Bits arrive LSB first. The character is rebuilt in parallel and its parity and stop bit are checked.

Configuration inputs set the character length (5 to 8 bits) and the parity mode (none, even, odd or a fixed stick value). The configuration is captured at each start bit. A finished character goes to a holding register and raises a data-ready flag, which the host clears with a read strobe. Error flags for framing, parity, overrun, break and false start stay set until the host pulses a clear input.

Top module: `uart_rx_os`

## Requirements
- R1: Samples are taken at three consecutive oversampling ticks around the centre of each bit, and the bit takes the 2-of-3 majority value. One disturbed sample leaves the bit unchanged. Two disturbed samples flip it.
- R2: If the voted start bit is high, the receiver goes back to idle without completing a character. It leaves data_rdy_o low and sets false_start_o.
- R3: len_sel_i selects the character length: 2'b00 = 5 bits, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8. The first received bit goes to data_o[0]. Bits above the selected length read as zero.
- R4: With par_en_i high and par_stick_i low, one parity bit follows the data. par_even_i = 1 requires an even count of ones over data plus parity, and par_even_i = 0 requires an odd count. A mismatch sets par_err_o. With par_en_i low, no parity bit is expected and par_err_o is never set.
- R5: With par_en_i and par_stick_i both high, the received parity bit is compared with a fixed value: 0 when par_even_i = 1, and 1 when par_even_i = 0.
- R6: A voted stop bit that is low sets frame_err_o. The character is still delivered. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: When the data bits, any parity bit and the stop bit are all voted low, brk_err_o and frame_err_o are both set, and a zero character is delivered. The held low level does not start another character.
- R8: data_rdy_o rises when a character completes and falls after a one-cycle rd_i pulse. data_o holds its value until the next character completes.
- R9: If a character completes while data_rdy_o is still set and rd_i is not pulsed in that cycle, ovr_err_o is set and data_o takes the new character.
- R10: All error flags are sticky. Only err_clr_i clears them, and a new error in the same cycle as the clear wins.
- R11: After reset, data_o is zero and data_rdy_o and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, OSR pulses per bit |
| rx_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Character length code |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity select (for stick mode, selects the fixed 0) |
| par_stick_i | input | 1 | Compare parity against a fixed value |
| rd_i | input | 1 | Host read strobe, clears data ready |
| err_clr_i | input | 1 | Host clear of all error flags |
| data_o | output | 8 | Last received character |
| data_rdy_o | output | 1 | Character waiting to be read |
| frame_err_o | output | 1 | Sticky framing error |
| par_err_o | output | 1 | Sticky parity error |
| ovr_err_o | output | 1 | Sticky overrun |
| brk_err_o | output | 1 | Sticky break detected |
| false_start_o | output | 1 | Sticky false start |

## Verification
The bench uses the default parameters: OSR = 16, VOTE_N = 3 and SYNC_STAGES = 2. It holds tick_i high, so every bit lasts exactly sixteen clocks. The bench can then place glitches on chosen ticks inside a bit and check the 2-of-3 vote. It can also cut a start pulse short of the sampling window and hold the line low past a full frame. A table of frames covers all four length codes and every parity mode, with correct and corrupted parity and a low stop bit. Directed sequences then cover overrun, sticky flags, false starts and break recovery.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } rx_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OSR    = 16,
  parameter int VOTE_N = 3,
  localparam int CNT_W = $clog2(OSR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             vote_o
);
  localparam int HALF  = VOTE_N / 2;
  localparam int LO    = OSR / 2 - HALF;
  localparam int HI    = OSR / 2 + HALF;
  localparam int ONE_W = $clog2(VOTE_N + 1);

  logic [VOTE_N-2:0] smp_q;
  logic [VOTE_N-1:0] all_smp;
  logic [ONE_W-1:0]  ones;
  logic              in_win;

  assign in_win = (int'(cnt_i) >= LO) && (int'(cnt_i) < HI);

  generate
    if (VOTE_N == 2) begin : g_short
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)               smp_q <= '1;
        else if (tick_i && in_win) smp_q <= rx_i;
    end else begin : g_long
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)               smp_q <= '1;
        else if (tick_i && in_win) smp_q <= {smp_q[VOTE_N-3:0], rx_i};
    end
  endgenerate

  // last sample is taken live at the decision tick
  assign all_smp = {smp_q, rx_i};

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_N; i++) ones = ones + ONE_W'(all_smp[i]);
  end

  assign vote_o = (int'(ones) > HALF);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int VOTE_N = 3,
  localparam int CNT_W = $clog2(OSR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             vote_i,
  input  rx_cfg_t          cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic [7:0]       data_o,
  output logic             pe_o,
  output logic             fe_o,
  output logic             brk_o,
  output logic             fs_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_DEC  = CNT_W'(OSR / 2 + VOTE_N / 2);

  rx_state_e  state_q;
  rx_cfg_t    cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0] idx_q;
  logic [7:0] shreg_q;
  logic       par_q;
  logic       zero_q;
  logic       dec_tick;
  logic       end_tick;
  logic       last_bit;
  logic       par_exp;
  logic       par_bad;

  assign dec_tick = tick_i && (cnt_q == CNT_DEC);
  assign end_tick = tick_i && (cnt_q == CNT_LAST);
  assign last_bit = (idx_q == ({1'b0, cfg_q.len} + 3'd4));

  assign par_exp = cfg_q.par_stick ? ~cfg_q.par_even
                 : (cfg_q.par_even ? ^shreg_q : ~^shreg_q);
  assign par_bad = cfg_q.par_en && (par_q != par_exp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b1;
      done_o  <= 1'b0;
      data_o  <= '0;
      pe_o    <= 1'b0;
      fe_o    <= 1'b0;
      brk_o   <= 1'b0;
      fs_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fs_o   <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) begin
              state_q <= ST_START;
              cfg_q   <= cfg_i;
              idx_q   <= '0;
              shreg_q <= '0;
              par_q   <= 1'b0;
              zero_q  <= 1'b1;
            end
          end
          ST_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (dec_tick && vote_i) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
              fs_o    <= 1'b1;
            end else if (end_tick) begin
              state_q <= ST_DATA;
              cnt_q   <= '0;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (dec_tick) begin
              shreg_q[idx_q] <= vote_i;
              if (vote_i) zero_q <= 1'b0;
            end
            if (end_tick) begin
              cnt_q <= '0;
              if (last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
              else          idx_q   <= idx_q + 1'b1;
            end
          end
          ST_PAR: begin
            cnt_q <= cnt_q + 1'b1;
            if (dec_tick) begin
              par_q <= vote_i;
              if (vote_i) zero_q <= 1'b0;
            end
            if (end_tick) begin
              state_q <= ST_STOP;
              cnt_q   <= '0;
            end
          end
          ST_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (dec_tick) begin
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              pe_o    <= par_bad;
              fe_o    <= ~vote_i;
              brk_o   <= ~vote_i & zero_q;
              cnt_q   <= '0;
              state_q <= vote_i ? ST_IDLE : ST_HOLD;
            end
          end
          ST_HOLD: begin
            cnt_q <= '0;
            if (rx_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [7:0] data_i,
  input  logic       pe_i,
  input  logic       fe_i,
  input  logic       brk_i,
  input  logic       fs_i,
  input  logic       rd_i,
  input  logic       clr_i,
  output logic [7:0] data_o,
  output logic       rdy_o,
  output logic       pe_o,
  output logic       fe_o,
  output logic       brk_o,
  output logic       ovr_o,
  output logic       fs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
      ovr_o  <= 1'b0;
      fs_o   <= 1'b0;
    end else begin
      if (done_i)    data_o <= data_i;
      if (done_i)    rdy_o  <= 1'b1;
      else if (rd_i) rdy_o  <= 1'b0;
      // set has priority over clear
      if (done_i && pe_i)               pe_o  <= 1'b1;
      else if (clr_i)                   pe_o  <= 1'b0;
      if (done_i && fe_i)               fe_o  <= 1'b1;
      else if (clr_i)                   fe_o  <= 1'b0;
      if (done_i && brk_i)              brk_o <= 1'b1;
      else if (clr_i)                   brk_o <= 1'b0;
      if (done_i && rdy_o && !rd_i)     ovr_o <= 1'b1;
      else if (clr_i)                   ovr_o <= 1'b0;
      if (fs_i)                         fs_o  <= 1'b1;
      else if (clr_i)                   fs_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int VOTE_N      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] len_sel_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       data_rdy_o,
  output logic       frame_err_o,
  output logic       par_err_o,
  output logic       ovr_err_o,
  output logic       brk_err_o,
  output logic       false_start_o
);
  localparam int CNT_W = $clog2(OSR);

  logic             rx_s;
  logic             vote;
  logic [CNT_W-1:0] cnt;
  rx_cfg_t          cfg;
  logic             frm_done;
  logic [7:0]       frm_data;
  logic             frm_pe, frm_fe, frm_brk, frm_fs;

  assign cfg = '{len: len_sel_i, par_en: par_en_i,
                 par_even: par_even_i, par_stick: par_stick_i};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_vote #(.OSR(OSR), .VOTE_N(VOTE_N)) u_vote (
    .clk_i, .rst_ni, .tick_i, .rx_i(rx_s), .cnt_i(cnt), .vote_o(vote)
  );

  uart_rx_frame #(.OSR(OSR), .VOTE_N(VOTE_N)) u_frame (
    .clk_i, .rst_ni, .tick_i, .rx_i(rx_s), .vote_i(vote), .cfg_i(cfg),
    .cnt_o(cnt), .done_o(frm_done), .data_o(frm_data), .pe_o(frm_pe),
    .fe_o(frm_fe), .brk_o(frm_brk), .fs_o(frm_fs)
  );

  uart_rx_status u_status (
    .clk_i, .rst_ni, .done_i(frm_done), .data_i(frm_data), .pe_i(frm_pe),
    .fe_i(frm_fe), .brk_i(frm_brk), .fs_i(frm_fs), .rd_i, .clr_i(err_clr_i),
    .data_o, .rdy_o(data_rdy_o), .pe_o(par_err_o), .fe_o(frame_err_o),
    .brk_o(brk_err_o), .ovr_o(ovr_err_o), .fs_o(false_start_o)
  );
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       err_clr_i,
  input logic       done_i,
  input logic       fs_i,
  input logic       rdy_i,
  input logic [7:0] data_i,
  input logic       ovr_i,
  input logic       fe_i,
  input logic       pe_i,
  input logic       brk_i
);
  AST_FS_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |-> !done_i); // R2
  AST_BRK_WITH_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> fe_i); // R7
  AST_RDY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rdy_i); // R8
  AST_RDY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !rdy_i); // R8
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_i)); // R8
  AST_OVR_ON_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && rdy_i && !rd_i |=> ovr_i); // R9
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_i && !err_clr_i |=> fe_i); // R10
  AST_PE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && !err_clr_i |=> pe_i); // R10
endmodule

bind uart_rx_os uart_rx_os_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .err_clr_i(err_clr_i),
  .done_i(frm_done), .fs_i(frm_fs), .rdy_i(data_rdy_o), .data_i(data_o),
  .ovr_i(ovr_err_o), .fe_i(frame_err_o), .pe_i(par_err_o), .brk_i(brk_err_o)
);

// File: tb/tb_uart_rx_os.sv
module tb_uart_rx_os;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] len = 2'b11;
  logic       pen = 1'b0, peven = 1'b0, pstick = 1'b0;
  logic       rd = 1'b0, clr = 1'b0;
  logic [7:0] data;
  logic       rdy, fe, pe, ovr, brk, fs;
  int         n_chk = 0, n_err = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  uart_rx_os dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rx_i(rx),
    .len_sel_i(len), .par_en_i(pen), .par_even_i(peven), .par_stick_i(pstick),
    .rd_i(rd), .err_clr_i(clr), .data_o(data), .data_rdy_o(rdy),
    .frame_err_o(fe), .par_err_o(pe), .ovr_err_o(ovr), .brk_err_o(brk),
    .false_start_o(fs)
  );

  typedef struct packed {
    logic [1:0] len;
    logic [7:0] din;
    logic       pen, even, stick, bad, stop;
    logic [7:0] exp_d;
    logic       exp_pe, exp_fe;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R3
    '{2'b00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0}, // R3
    '{2'b01, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0}, // R3
    '{2'b10, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0}, // R3
    '{2'b11, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0}, // R4
    '{2'b11, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0}, // R4
    '{2'b10, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0}, // R4
    '{2'b11, 8'h07, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0}, // R5
    '{2'b11, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0}, // R5
    '{2'b11, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one bit of 16 ticks, inverting the level on ticks whose mask bit is set
  task automatic send_bit(input logic v, input logic [15:0] gl);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rx = v ^ gl[i];
    end
  endtask

  task automatic send_frame(input logic [1:0] l, input logic [7:0] d, input logic has_par,
                            input logic pb, input logic stop, input int gl_bit,
                            input logic [15:0] gl);
    send_bit(1'b0, 16'h0);
    for (int b = 0; b < int'(l) + 5; b++) send_bit(d[b], (b == gl_bit) ? gl : 16'h0);
    if (has_par) send_bit(pb, 16'h0);
    send_bit(stop, 16'h0);
    @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic ack();
    @(negedge clk);
    rd = 1'b1; clr = 1'b1;
    @(negedge clk);
    rd = 1'b0; clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R11 data", data, 0);
    chk("R11 flags", {rdy, fe, pe, ovr, brk, fs}, 0);
    rst_n = 1'b1;
    idle(20);
    chk("R11 after release", {rdy, fe, pe, ovr, brk, fs, data}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      logic [7:0] m = v.din & (8'hFF >> (3 - v.len));
      logic pb = v.stick ? ~v.even : (v.even ? ^m : ~^m);
      pb = pb ^ v.bad;
      len = v.len; pen = v.pen; peven = v.even; pstick = v.stick;
      send_frame(v.len, v.din, v.pen, pb, v.stop, -1, 16'h0);
      idle(16);
      chk("R3/R8 data", data, v.exp_d);
      chk("R8 ready", rdy, 1);
      chk(v.stick ? "R5 parity" : "R4 parity", pe, v.exp_pe);
      chk("R6 framing", fe, v.exp_fe);
      chk("R9/R7 no ovr/brk", {ovr, brk, fs}, 0);
      ack();
      idle(2);
      chk("R8 rd clears", rdy, 0);
      chk("R10 clear", {fe, pe}, 0);
    end

    // R1 majority vote
    len = 2'b11; pen = 1'b0; pstick = 1'b0;
    send_frame(2'b11, 8'h00, 1'b0, 1'b0, 1'b1, 0, 16'h0200);
    idle(16);
    chk("R1 single glitch ignored", data, 8'h00);
    ack();
    send_frame(2'b11, 8'h00, 1'b0, 1'b0, 1'b1, 1, 16'h0300);
    idle(16);
    chk("R1 two glitches flip", data, 8'h02);
    ack();
    send_frame(2'b11, 8'hFF, 1'b0, 1'b0, 1'b1, 3, 16'h8001);
    idle(16);
    chk("R1 edge glitches ignored", data, 8'hFF);
    ack();

    // R2 false start
    @(negedge clk); rx = 1'b0;
    idle(4); rx = 1'b1;
    idle(40);
    chk("R2 false start flag", fs, 1);
    chk("R2 no data", rdy, 0);
    ack();
    idle(2);
    chk("R2 flag clears", fs, 0);

    // R9 overrun
    send_frame(2'b11, 8'h11, 1'b0, 1'b0, 1'b1, -1, 16'h0);
    idle(16);
    send_frame(2'b11, 8'h22, 1'b0, 1'b0, 1'b1, -1, 16'h0);
    idle(16);
    chk("R9 overrun", ovr, 1);
    chk("R9 new data", data, 8'h22);
    ack();

    // R10 sticky across a good frame
    pen = 1'b1; peven = 1'b1;
    send_frame(2'b11, 8'h01, 1'b1, 1'b0, 1'b1, -1, 16'h0);
    idle(16);
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
    send_frame(2'b11, 8'h03, 1'b1, 1'b0, 1'b1, -1, 16'h0);
    idle(16);
    chk("R10 pe sticky", pe, 1);
    ack();
    idle(2);
    chk("R10 pe cleared", pe, 0);
    pen = 1'b0;

    // R7 break
    @(negedge clk); rx = 1'b0;
    idle(320);
    rx = 1'b1;
    idle(32);
    chk("R7 break", brk, 1);
    chk("R7 framing", fe, 1);
    chk("R7 zero char", {rdy, data}, 9'h100);
    ack();
    idle(40);
    chk("R7 no extra char", {rdy, brk, fe, fs}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule